// File: doc/BRIEF.md
# Sample Memory Byte Readout Controller

This block hands bytes out of a byte-wide sample RAM to a host link, one byte for each request the host makes. It decodes the 16-bit command words the host sends. Four flag bits and an 8-bit instruction field are taken from each word. When the transfer-enable flag is set, every stop-bit pulse from the host asks for exactly one byte. The block issues a RAM read at the current address and delivers the returned byte with a one-cycle valid strobe to the line serializer.

The RAM address counter lives in this block, and the sample recorder shares it. The recorder steps the counter once for each byte it stores, and clears it to zero when its session ends. Reads never overlap a recording session. A request that arrives while the recorder is active is held, and it is served in the first cycle after the session finishes. At most one request waits at any time.

Top module: `sample_byte_reader`

## Requirements
- R1: On a `cmd_valid` cycle, bit 7 of `cmd_word` is loaded into `wake`, bit 6 into `logic_ret_en` and bit 4 into `xfer_en`. All three are visible from the next cycle and are held until the next command. Word 0x00D0 therefore sets all three flags.
- R2: A command with bit 5 set raises `instr_stb` for exactly one cycle, in the cycle after `cmd_valid`, with `instr` equal to bits 15:8. A command with bit 5 clear gives no strobe. Bits 3:0 have no effect on anything.
- R3: With `xfer_en` set, no session active and no request outstanding, a `stop_pulse` raises `ram_rd` in the same cycle. `tx_valid` is then high in the next cycle, carrying the RAM byte at the address presented with the read.
- R4: Every read advances `ram_addr` by one, and the address wraps from its all-ones value to zero.
- R5: A `stop_pulse` accepted while `rec_active` is high is held. Its read is issued in the first cycle in which `rec_active` is low.
- R6: `ram_rd` is never high while `rec_active` is high.
- R7: A `stop_pulse` that arrives while a request is waiting or a read is in flight is ignored. It produces no extra byte and no address step.
- R8: With `xfer_en` clear, a `stop_pulse` produces no read and no byte, and `ram_addr` is unchanged.
- R9: `rec_step` advances `ram_addr` by one. `rec_clear` sets it to zero and takes priority over any step.
- R10: After reset, `ram_addr` is zero and `tx_valid`, `instr_stb`, `wake`, `logic_ret_en` and `xfer_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Host command word |
| stop_pulse | input | 1 | Host stop bit, requests one byte |
| rec_active | input | 1 | Recording session in progress |
| rec_step | input | 1 | Recorder stored a byte, advance address |
| rec_clear | input | 1 | Recorder session ended, zero address |
| ram_addr | output | ADDR_W | Shared RAM byte address |
| ram_rd | output | 1 | RAM read enable |
| ram_rdata | input | DATA_W | RAM read data |
| tx_byte | output | DATA_W | Byte for the serializer |
| tx_valid | output | 1 | tx_byte is valid this cycle |
| wake | output | 1 | Wake flag from last command |
| logic_ret_en | output | 1 | Logic return enable from last command |
| xfer_en | output | 1 | Byte transfer enable from last command |
| instr | output | 8 | Instruction field of last executed command |
| instr_stb | output | 1 | Instruction execute strobe |

## Verification
The bench builds the block with a 10-bit address and a read latency of one cycle. The narrow address lets recorder steps walk the counter to its all-ones value within a short run, so the wrap to zero is reached on a real read. The single-cycle latency puts each byte in the cycle directly after its read. That spacing exposes a second stop pulse landing while a read is in flight, and a request released in the same cycle that a session ends.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
   localparam int CMD_W    = 16;
   localparam int INSTR_HI = 15;
   localparam int INSTR_LO = 8;
   localparam int INSTR_W  = INSTR_HI - INSTR_LO + 1;
   localparam int WAKE_BIT = 7;
   localparam int LRET_BIT = 6;
   localparam int EXEC_BIT = 5;
   localparam int XFER_BIT = 4;

   typedef struct packed {
      logic wake;
      logic lret;
      logic xfer;
   } mode_t;

   function automatic mode_t decode_mode(input logic [CMD_W-1:0] w);
      mode_t m;
      m.wake = w[WAKE_BIT];
      m.lret = w[LRET_BIT];
      m.xfer = w[XFER_BIT];
      return m;
   endfunction
endpackage

// File: rtl/sbr_cmd_decode.sv
module sbr_cmd_decode
   import sbr_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [CMD_W-1:0]     cmd_word,
   output mode_t                mode_o,
   output logic [INSTR_W-1:0]   instr_o,
   output logic                 instr_stb_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_o      <= '0;
         instr_o     <= '0;
         instr_stb_o <= 1'b0;
      end else begin
         instr_stb_o <= 1'b0;
         if (cmd_valid) begin
            mode_o <= decode_mode(cmd_word);
            if (cmd_word[EXEC_BIT]) begin
               instr_o     <= cmd_word[INSTR_HI:INSTR_LO];
               instr_stb_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sbr_addr_ctr.sv
module sbr_addr_ctr #(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (clr)  addr <= '0;
      else if (inc)  addr <= addr + ONE;
   end
endmodule

// File: rtl/sbr_read_seq.sv
module sbr_read_seq #(
   parameter int RD_LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_pulse,
   input  logic xfer_en,
   input  logic rec_active,
   output logic rd_go,
   output logic rd_valid
);
   logic              pending_q;
   logic              inflight;
   logic              req_now;
   logic              want;
   logic [RD_LAT-1:0] vpipe;

   assign inflight = |vpipe;
   assign req_now  = stop_pulse & xfer_en & ~pending_q & ~inflight;
   assign want     = pending_q | req_now;
   assign rd_go    = want & ~rec_active;
   assign rd_valid = vpipe[RD_LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) pending_q <= 1'b0;
      else        pending_q <= want & rec_active;
   end

   generate
      if (RD_LAT < 1 || RD_LAT > 2) begin : g_bad_lat
         $error("sbr_read_seq: RD_LAT must be 1 or 2");
      end else if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk) begin
            if (!rst_n) vpipe <= '0;
            else        vpipe <= rd_go;
         end
      end else begin : g_latn
         always_ff @(posedge clk) begin
            if (!rst_n) vpipe <= '0;
            else        vpipe <= {vpipe[RD_LAT-2:0], rd_go};
         end
      end
   endgenerate
endmodule

// File: rtl/sample_byte_reader.sv
module sample_byte_reader
   import sbr_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8,
   parameter int RD_LAT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   input  logic [CMD_W-1:0]    cmd_word,
   input  logic                stop_pulse,
   input  logic                rec_active,
   input  logic                rec_step,
   input  logic                rec_clear,
   output logic [ADDR_W-1:0]   ram_addr,
   output logic                ram_rd,
   input  logic [DATA_W-1:0]   ram_rdata,
   output logic [DATA_W-1:0]   tx_byte,
   output logic                tx_valid,
   output logic                wake,
   output logic                logic_ret_en,
   output logic                xfer_en,
   output logic [INSTR_W-1:0]  instr,
   output logic                instr_stb
);
   generate
      if (ADDR_W < 2 || DATA_W < 1) begin : g_bad_cfg
         $error("sample_byte_reader: ADDR_W must be >= 2 and DATA_W >= 1");
      end
   endgenerate

   mode_t mode;
   logic  rd_go;

   sbr_cmd_decode u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .cmd_word    (cmd_word),
      .mode_o      (mode),
      .instr_o     (instr),
      .instr_stb_o (instr_stb)
   );

   sbr_read_seq #(.RD_LAT(RD_LAT)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_pulse (stop_pulse),
      .xfer_en    (mode.xfer),
      .rec_active (rec_active),
      .rd_go      (rd_go),
      .rd_valid   (tx_valid)
   );

   sbr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rec_clear),
      .inc   (rd_go | rec_step),
      .addr  (ram_addr)
   );

   assign ram_rd       = rd_go;
   assign tx_byte      = ram_rdata;
   assign wake         = mode.wake;
   assign logic_ret_en = mode.lret;
   assign xfer_en      = mode.xfer;
endmodule

// File: rtl/sample_byte_reader_chk.sv
module sample_byte_reader_chk #(
   parameter int ADDR_W = 19,
   parameter int RD_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [15:0]       cmd_word,
   input logic              rec_active,
   input logic              rec_step,
   input logic              rec_clear,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              ram_rd,
   input logic              tx_valid,
   input logic [7:0]        instr,
   input logic              instr_stb
);
   assert_no_read_in_session_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_active |-> !ram_rd);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd || rec_step) && !rec_clear |=> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

   assert_addr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_clear |=> ram_addr == '0);

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_rd && !rec_step && !rec_clear |=> $stable(ram_addr));

   assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(ram_rd, RD_LAT));

   assert_one_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd |=> !ram_rd);

   assert_instr_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_word[5] |=> instr_stb && instr == $past(cmd_word[15:8]));

   assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_word[5]) |=> !instr_stb);
endmodule

bind sample_byte_reader sample_byte_reader_chk #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_word   (cmd_word),
   .rec_active (rec_active),
   .rec_step   (rec_step),
   .rec_clear  (rec_clear),
   .ram_addr   (ram_addr),
   .ram_rd     (ram_rd),
   .tx_valid   (tx_valid),
   .instr      (instr),
   .instr_stb  (instr_stb)
);

// File: tb/test_sample_byte_reader.sv
`timescale 1ns/1ps
module test_sample_byte_reader;
   localparam int AW = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [15:0]   cmd_word = '0;
   logic          stop_pulse = 1'b0;
   logic          rec_active = 1'b0;
   logic          rec_step = 1'b0;
   logic          rec_clear = 1'b0;
   logic [AW-1:0] ram_addr;
   logic          ram_rd;
   logic [7:0]    ram_rdata = '0;
   logic [7:0]    tx_byte;
   logic          tx_valid;
   logic          wake, logic_ret_en, xfer_en;
   logic [7:0]    instr;
   logic          instr_stb;

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] exp_addr = '0;
   logic          exp_xfer = 1'b0;
   int            n_chk = 0;
   int            n_fail = 0;

   always #10 clk = ~clk;

   sample_byte_reader #(.ADDR_W(AW), .DATA_W(8), .RD_LAT(1)) i_sample_byte_reader (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
      .stop_pulse(stop_pulse), .rec_active(rec_active), .rec_step(rec_step),
      .rec_clear(rec_clear), .ram_addr(ram_addr), .ram_rd(ram_rd),
      .ram_rdata(ram_rdata), .tx_byte(tx_byte), .tx_valid(tx_valid),
      .wake(wake), .logic_ret_en(logic_ret_en), .xfer_en(xfer_en),
      .instr(instr), .instr_stb(instr_stb)
   );

   always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 29) + ((i >> 8) * 7) + 3);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_cmd(input logic [15:0] w);
      @(negedge clk); cmd_valid = 1'b1; cmd_word = w;
      @(negedge clk); cmd_valid = 1'b0; #2;
      exp_xfer = w[4];
      chk({wake, logic_ret_en, xfer_en} == {w[7], w[6], w[4]}, "R1 flags",
          {wake, logic_ret_en, xfer_en}, {w[7], w[6], w[4]});
      chk(instr_stb == w[5], "R2 strobe", instr_stb, w[5]);
      if (w[5]) chk(instr == w[15:8], "R2 instr", instr, w[15:8]);
      @(negedge clk); #2;
      chk(!instr_stb, "R2 single strobe", instr_stb, 0);
   endtask

   task automatic read_one();
      @(negedge clk); stop_pulse = 1'b1; #2;
      chk(ram_rd == exp_xfer, exp_xfer ? "R3 read issue" : "R8 no read", ram_rd, exp_xfer);
      @(negedge clk); stop_pulse = 1'b0; #2;
      if (exp_xfer) begin
         chk(tx_valid && tx_byte == mem[exp_addr], "R3 byte", {tx_valid, tx_byte},
             {1'b1, mem[exp_addr]});
         exp_addr = exp_addr + 1'b1;
      end else begin
         chk(!tx_valid, "R8 no byte", tx_valid, 0);
      end
      chk(ram_addr == exp_addr, "R4 address", ram_addr, exp_addr);
   endtask

   task automatic rec_steps(input int n);
      @(negedge clk); rec_active = 1'b1;
      for (int k = 0; k < n; k++) begin
         rec_step = 1'b1;
         @(negedge clk);
      end
      rec_step = 1'b0; rec_active = 1'b0;
      exp_addr = AW'(exp_addr + n);
      #2 chk(ram_addr == exp_addr, "R9 step", ram_addr, exp_addr);
   endtask

   task automatic rec_clr();
      @(negedge clk); rec_clear = 1'b1; rec_step = 1'b1;
      @(negedge clk); rec_clear = 1'b0; rec_step = 1'b0; #2;
      exp_addr = '0;
      chk(ram_addr == 0, "R9 clear", ram_addr, 0);
   endtask

   initial begin
      #4_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < DEPTH; i++) mem[i] = pat(i);
      repeat (3) @(negedge clk);
      #2;
      chk(ram_addr == 0 && !tx_valid && !instr_stb, "R10 reset outputs",
          {ram_addr, tx_valid, instr_stb}, 0);
      chk({wake, logic_ret_en, xfer_en} == 3'b000, "R10 reset flags",
          {wake, logic_ret_en, xfer_en}, 0);
      @(negedge clk); rst_n = 1'b1;

      // R8: transfer disabled
      read_one();
      // R1: prepare word 0x00D0, plus don't-care low bits
      do_cmd(16'h00DF);
      chk({wake, logic_ret_en, xfer_en} == 3'b111, "R1 prepare word",
          {wake, logic_ret_en, xfer_en}, 3'b111);
      // R2: executed instruction
      do_cmd(16'hA5F0);
      read_one(); read_one(); read_one();

      // R5: request held across a session
      rec_steps(5);
      @(negedge clk); rec_active = 1'b1; stop_pulse = 1'b1; #2;
      chk(!ram_rd, "R6 no read in session", ram_rd, 0);
      @(negedge clk); stop_pulse = 1'b0; rec_step = 1'b1; #2;
      chk(!ram_rd && !tx_valid, "R5 held", {ram_rd, tx_valid}, 0);
      // R7: second stop while pending is dropped
      @(negedge clk); rec_step = 1'b0; stop_pulse = 1'b1; #2;
      chk(!ram_rd, "R6 still held", ram_rd, 0);
      @(negedge clk); stop_pulse = 1'b0;
      exp_addr = exp_addr + 1'b1;
      @(negedge clk); rec_active = 1'b0; #2;
      chk(ram_rd && ram_addr == exp_addr, "R5 release", {ram_rd, ram_addr}, {1'b1, exp_addr});
      @(negedge clk); #2;
      chk(tx_valid && tx_byte == mem[exp_addr], "R5 byte", tx_byte, mem[exp_addr]);
      exp_addr = exp_addr + 1'b1;
      @(negedge clk); #2;
      chk(!tx_valid && !ram_rd && ram_addr == exp_addr, "R7 single byte after pending",
          {tx_valid, ram_rd, ram_addr}, {2'b00, exp_addr});

      // R7: stop while read in flight
      @(negedge clk); stop_pulse = 1'b1; #2;
      chk(ram_rd, "R3 read", ram_rd, 1);
      @(negedge clk); #2;
      chk(tx_valid && !ram_rd, "R7 in flight ignored", {tx_valid, ram_rd}, 2'b10);
      exp_addr = exp_addr + 1'b1;
      @(negedge clk); stop_pulse = 1'b0; #2;
      chk(!tx_valid && ram_addr == exp_addr, "R7 no extra step", ram_addr, exp_addr);

      // R4: wrap
      rec_clr();
      rec_steps(DEPTH - 1);
      chk(ram_addr == AW'(DEPTH - 1), "R4 top address", ram_addr, DEPTH - 1);
      read_one();
      chk(ram_addr == 0, "R4 wrap", ram_addr, 0);

      // Random mix
      for (int it = 0; it < 300; it++) begin
         case ($urandom % 6)
            0, 1, 2: read_one();
            3: do_cmd({8'($urandom), 1'b1, 1'($urandom), 1'($urandom),
                       ($urandom % 4 != 0), 4'($urandom)});
            4: rec_steps(1 + ($urandom % 20));
            default: if ($urandom % 3 == 0) rec_clr(); else read_one();
         endcase
      end

      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule